// File: doc/BRIEF.md
# SPI Paged Register Access Slave

This block is an SPI slave (mode 0, single active-low chip select) that turns a compact host framing into bursts of 16-bit register reads and writes on a simple synchronous register port. The SPI pins are oversampled by the system clock through a two-flop synchronizer. A frame begins with a command byte. That byte picks either a short header that reaches page 0 directly, or a longer header that names a page and can also reach a dedicated firmware window page.

Once the header is complete, the block moves 16-bit words, most-significant byte first, in either direction. It advances the word offset after each word and wraps it within the 128-word page. For reads, the first word is prefetched as soon as the header ends, and each following word is prefetched as the previous one completes. Raising chip select aborts the frame at any point.

Top module: `spi_paged_reg_slave`

## Requirements
- R1: After reset, miso_o is low and reg_req_o is low.
- R2: A first byte with bit 7 set that is not 0xFE is a direct header. The access targets page 0 (reg_fw_o low, reg_page_o 0), the word offset is the byte's low 7 bits, and the next byte is the length byte.
- R3: A first byte of 0xFE starts a paged header: page byte, then offset byte (low 7 bits are the word offset), then length byte. A page byte p other than 0xFF drives reg_page_o = p+1 with reg_fw_o low.
- R4: A page byte of 0xFF drives reg_fw_o high and reg_page_o 0.
- R5: In the length byte, the low 7 bits give the number of 16-bit words minus one. Bit 7 set selects a write burst and bit 7 clear selects a read burst.
- R6: In a write burst, each pair of data bytes forms one word, high byte first. One write request carrying that word is issued after the second byte arrives.
- R7: In a read burst, the word at the current offset is shifted out on miso_o MSB first. The first bit is present from the first data byte that follows the header, and bits advance on SCLK falling edges.
- R8: The word offset increments after each word of a burst and wraps from 127 to 0.
- R9: A burst carries at most 128 words. Bytes after the last word cause no register access, and miso_o stays low during them.
- R10: Chip select going high discards any partial word without writing it and returns the parser to the command byte.
- R11: A first byte with bit 7 clear makes the whole frame cause no register access, and miso_o stays low for the rest of that frame.
- R12: Every register request lasts one clock cycle. Read data is taken on reg_rdata_i in the cycle after the request. SCLK period must be at least 12 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| reg_req_o | output | 1 | Register access request, one cycle |
| reg_we_o | output | 1 | Request is a write |
| reg_fw_o | output | 1 | Request targets the firmware window page |
| reg_page_o | output | 8 | Logical page number of the request |
| reg_addr_o | output | 7 | Word offset within the page |
| reg_wdata_o | output | 16 | Write data |
| reg_rdata_i | input | 16 | Read data, valid the cycle after a read request |

## Verification
The assertions check on every cycle the following timing and state rules:
- each request is a single-cycle pulse;
- a write request only follows a freshly received byte;
- the firmware flag never coexists with a nonzero page;
- after chip select rises, the parser is back at the command byte and miso is quiet.

Header decoding, page arithmetic, MSB-first ordering, offset wrap, the 128-word limit and the discarding of partial words depend on whole frames. Only the bench's scenarios can show these: they sweep page bytes and compare logged register traffic and received words against values computed from the frame contents.

// File: rtl/spi_paged_pkg.sv
package spi_paged_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int OFFS_W = 7;
  localparam int PAGE_W = 8;
  localparam int LEN_W  = 7;

  localparam logic [BYTE_W-1:0] CMD_PAGED = 8'hFE;
  localparam logic [BYTE_W-1:0] PAGE_FW   = 8'hFF;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_PAGE,
    ST_OFFS,
    ST_LEN,
    ST_DATA,
    ST_DROP
  } hdr_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  // bit 2: sclk, bit 1: cs_n, bit 0: mosi
  localparam logic [2:0] IDLE_PINS = 3'b010;

  logic [2:0] stg_q [STAGES];
  logic       sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= IDLE_PINS;
      sclk_prev_q <= 1'b0;
    end else begin
      stg_q[0] <= {sclk_i, cs_ni, mosi_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sclk_prev_q <= stg_q[STAGES-1][2];
    end
  end

  assign cs_act_o = ~stg_q[STAGES-1][1];
  assign mosi_o   = stg_q[STAGES-1][0];
  assign rise_o   = cs_act_o &  stg_q[STAGES-1][2] & ~sclk_prev_q;
  assign fall_o   = cs_act_o & ~stg_q[STAGES-1][2] &  sclk_prev_q;
endmodule

// File: rtl/spi_rx_framer.sv
module spi_rx_framer
  import spi_paged_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  logic [BIT_CNT_W-1:0] bit_cnt_q;
  logic [BYTE_W-2:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q    <= '0;
      sh_q         <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (!cs_act_i) begin
        bit_cnt_q <= '0;
      end else if (rise_i) begin
        sh_q      <= {sh_q[BYTE_W-3:0], mosi_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == BIT_CNT_W'(BYTE_W - 1)) begin
          byte_o       <= {sh_q, mosi_i};
          byte_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_paged_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              bit_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  sent_q;  // rising edges since load, wraps per word

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      sent_q <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      sent_q <= '0;
    end else begin
      if (rise_i) sent_q <= sent_q + 1'b1;
      // falling edge after a word boundary keeps the freshly loaded MSB
      if (fall_i && sent_q != '0) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[WORD_W-1];
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_paged_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              req_o,
  output logic              we_o,
  output logic              fw_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFFS_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              tx_load_o,
  output logic              rd_mode_o
);
  hdr_state_e        state_q;
  logic              fw_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFFS_W-1:0] offs_q;
  logic [LEN_W-1:0]  left_q;
  logic              wr_q;
  logic              phase_q;
  logic [BYTE_W-1:0] hold_q;
  logic              req_q;
  logic              we_q;
  logic              rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      fw_q      <= 1'b0;
      page_q    <= '0;
      offs_q    <= '0;
      left_q    <= '0;
      wr_q      <= 1'b0;
      phase_q   <= 1'b0;
      hold_q    <= '0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      addr_o    <= '0;
      wdata_o   <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      req_q     <= 1'b0;
      rd_pend_q <= req_q & ~we_q;
      if (!cs_act_i) begin
        state_q <= ST_CMD;
        phase_q <= 1'b0;
      end else if (byte_valid_i) begin
        unique case (state_q)
          ST_CMD: begin
            if (byte_i == CMD_PAGED) begin
              state_q <= ST_PAGE;
            end else if (byte_i[BYTE_W-1]) begin
              fw_q    <= 1'b0;
              page_q  <= '0;
              offs_q  <= byte_i[OFFS_W-1:0];
              state_q <= ST_LEN;
            end else begin
              state_q <= ST_DROP;
            end
          end
          ST_PAGE: begin
            if (byte_i == PAGE_FW) begin
              fw_q   <= 1'b1;
              page_q <= '0;
            end else begin
              fw_q   <= 1'b0;
              page_q <= byte_i + 1'b1;
            end
            state_q <= ST_OFFS;
          end
          ST_OFFS: begin
            offs_q  <= byte_i[OFFS_W-1:0];
            state_q <= ST_LEN;
          end
          ST_LEN: begin
            wr_q    <= byte_i[BYTE_W-1];
            left_q  <= byte_i[LEN_W-1:0];
            phase_q <= 1'b0;
            state_q <= ST_DATA;
            if (!byte_i[BYTE_W-1]) begin
              req_q  <= 1'b1;
              we_q   <= 1'b0;
              addr_o <= offs_q;
            end
          end
          ST_DATA: begin
            if (!phase_q) begin
              hold_q  <= byte_i;
              phase_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              if (wr_q) begin
                req_q   <= 1'b1;
                we_q    <= 1'b1;
                addr_o  <= offs_q;
                wdata_o <= {hold_q, byte_i};
              end
              if (left_q == '0) begin
                state_q <= ST_DROP;
              end else begin
                left_q <= left_q - 1'b1;
                offs_q <= offs_q + 1'b1;
                if (!wr_q) begin
                  req_q  <= 1'b1;
                  we_q   <= 1'b0;
                  addr_o <= offs_q + 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign req_o     = req_q;
  assign we_o      = we_q;
  assign fw_o      = fw_q;
  assign page_o    = page_q;
  assign tx_load_o = rd_pend_q;
  assign rd_mode_o = (state_q == ST_DATA) && !wr_q;

  assert_single_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  assert_wr_after_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && we_q) |-> $past(byte_valid_i));

  assert_abort_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> state_q == ST_CMD);

  assert_fw_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_q |-> page_q == '0);
endmodule

// File: rtl/spi_paged_reg_slave.sv
module spi_paged_reg_slave
  import spi_paged_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic              reg_fw_o,
  output logic [PAGE_W-1:0] reg_page_o,
  output logic [OFFS_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i
);
  logic              rise, fall, cs_act, mosi_s;
  logic              byte_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_load, rd_mode, tx_bit;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_i),
    .cs_ni    (cs_ni),
    .mosi_i   (mosi_i),
    .rise_o   (rise),
    .fall_o   (fall),
    .cs_act_o (cs_act),
    .mosi_o   (mosi_s)
  );

  spi_rx_framer u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .rise_i       (rise),
    .mosi_i       (mosi_s),
    .byte_valid_o (byte_valid),
    .byte_o       (rx_byte)
  );

  spi_burst_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_act_i     (cs_act),
    .byte_valid_i (byte_valid),
    .byte_i       (rx_byte),
    .req_o        (reg_req_o),
    .we_o         (reg_we_o),
    .fw_o         (reg_fw_o),
    .page_o       (reg_page_o),
    .addr_o       (reg_addr_o),
    .wdata_o      (reg_wdata_o),
    .tx_load_o    (tx_load),
    .rd_mode_o    (rd_mode)
  );

  spi_tx_shift u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (reg_rdata_i),
    .rise_i (rise),
    .fall_i (fall),
    .bit_o  (tx_bit)
  );

  assign miso_o = rd_mode & tx_bit;

  assert_miso_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !miso_o);
endmodule

// File: tb/tb_spi_paged_reg_slave.sv
module tb_spi_paged_reg_slave;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, req, we, fw;
  logic [7:0]  page;
  logic [6:0]  addr;
  logic [15:0] wdata, rdata;

  int n_run = 0, n_fail = 0;
  logic [7:0] tx_buf [0:299];
  logic [7:0] rx_buf [0:299];

  // register model logs
  int          wr_n = 0, rd_n = 0, dbl_req = 0;
  logic [6:0]  wr_addr [0:511];
  logic [15:0] wr_data [0:511];
  logic [7:0]  wr_page [0:511];
  logic [6:0]  rd_addr [0:511];
  logic [7:0]  rd_page [0:511];
  logic        rd_fw   [0:511];
  logic        req_prev = 1'b0;

  always #5 clk = ~clk;

  spi_paged_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .reg_req_o(req), .reg_we_o(we), .reg_fw_o(fw),
    .reg_page_o(page), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  function automatic logic [15:0] mdl(input logic f, input logic [7:0] p, input logic [6:0] a);
    return {p ^ (f ? 8'hA5 : 8'h00), f, a};
  endfunction

  always @(posedge clk) begin
    req_prev <= req;
    if (req && req_prev) dbl_req <= dbl_req + 1;
    if (req && we) begin
      wr_addr[wr_n] <= addr; wr_data[wr_n] <= wdata; wr_page[wr_n] <= page;
      wr_n <= wr_n + 1;
    end
    if (req && !we) begin
      rdata <= mdl(fw, page, addr);
      rd_addr[rd_n] <= addr; rd_page[rd_n] <= page; rd_fw[rd_n] <= fw;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input int nb);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      xfer(tx_buf[b], r);
      rx_buf[b] = r;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int wb, rb;
    logic [7:0] pb;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    chk(miso == 1'b0, "R1 miso in reset", miso, 0);
    chk(req == 1'b0, "R1 req in reset", req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(miso == 1'b0 && req == 1'b0, "R1 after reset", {miso, req}, 0);

    // R2 R7 R8: direct read of 3 words at offset 5
    rb = rd_n;
    tx_buf[0] = 8'h85; tx_buf[1] = 8'h02;
    for (int i = 2; i < 8; i++) tx_buf[i] = 8'h00;
    frame(8);
    chk(rd_n - rb == 3, "R5 read word count", rd_n - rb, 3);
    for (int i = 0; i < 3; i++) begin
      w = {rx_buf[2+2*i], rx_buf[3+2*i]};
      chk(w == mdl(1'b0, 8'd0, 7'(5+i)), "R7 direct read data", w, mdl(1'b0, 8'd0, 7'(5+i)));
      chk(rd_addr[rb+i] == 7'(5+i) && rd_page[rb+i] == 0 && !rd_fw[rb+i],
          "R2 R8 direct read addr", rd_addr[rb+i], 5+i);
    end

    // R3 R4: paged read sweep over page byte values
    for (int p = 0; p < 256; p += 9) begin
      for (int k = 0; k < 2; k++) begin
        pb = (k == 0) ? 8'(p) : 8'(255 - p);
        rb = rd_n;
        tx_buf[0] = 8'hFE; tx_buf[1] = pb; tx_buf[2] = {1'b1, pb[6:0]}; tx_buf[3] = 8'h00;
        tx_buf[4] = 8'h00; tx_buf[5] = 8'h00;
        frame(6);
        w = {rx_buf[4], rx_buf[5]};
        if (pb == 8'hFF) begin
          chk(rd_n - rb == 1 && rd_fw[rb] && rd_page[rb] == 0, "R4 fw page select",
              {rd_fw[rb], rd_page[rb]}, 9'h100);
          chk(w == mdl(1'b1, 8'd0, pb[6:0]), "R4 fw page data", w, mdl(1'b1, 8'd0, pb[6:0]));
        end else begin
          chk(rd_n - rb == 1 && !rd_fw[rb] && rd_page[rb] == pb + 1 && rd_addr[rb] == pb[6:0],
              "R3 paged page/offset", {rd_fw[rb], rd_page[rb], rd_addr[rb]}, {1'b0, pb + 8'd1, pb[6:0]});
          chk(w == mdl(1'b0, pb + 8'd1, pb[6:0]), "R3 R7 paged read data", w, mdl(1'b0, pb + 8'd1, pb[6:0]));
        end
      end
    end

    // R5 R6: direct write of 2 words at offset 10
    wb = wr_n;
    tx_buf[0] = 8'h8A; tx_buf[1] = 8'h81;
    tx_buf[2] = 8'h12; tx_buf[3] = 8'h34; tx_buf[4] = 8'hAB; tx_buf[5] = 8'hCD;
    frame(6);
    chk(wr_n - wb == 2, "R5 write count", wr_n - wb, 2);
    chk(wr_data[wb] == 16'h1234 && wr_addr[wb] == 10, "R6 write word0", wr_data[wb], 16'h1234);
    chk(wr_data[wb+1] == 16'hABCD && wr_addr[wb+1] == 11, "R6 write word1", wr_data[wb+1], 16'hABCD);

    // R8: paged write wraps the offset
    wb = wr_n;
    tx_buf[0] = 8'hFE; tx_buf[1] = 8'h10; tx_buf[2] = 8'h7E; tx_buf[3] = 8'h83;
    for (int i = 0; i < 8; i++) tx_buf[4+i] = 8'(16 * i + 3);
    frame(12);
    chk(wr_n - wb == 4, "R8 wrap count", wr_n - wb, 4);
    for (int i = 0; i < 4; i++)
      chk(wr_addr[wb+i] == 7'(126 + i) && wr_page[wb+i] == 8'h11 &&
          wr_data[wb+i] == {8'(32*i+3), 8'(32*i+19)}, "R8 wrap addr", wr_addr[wb+i], (126+i) % 128);

    // R9: maximum burst of 128 words plus two trailing bytes
    wb = wr_n;
    tx_buf[0] = 8'h80; tx_buf[1] = 8'hFF;
    for (int i = 0; i < 130; i++) begin tx_buf[2+2*i] = 8'(i); tx_buf[3+2*i] = 8'(~i); end
    frame(262);
    chk(wr_n - wb == 128, "R9 max burst count", wr_n - wb, 128);
    chk(wr_addr[wb+127] == 127 && wr_data[wb+127] == {8'd127, 8'd128}, "R9 last word",
        wr_data[wb+127], {8'd127, 8'd128});

    // R9: trailing bytes after a read burst
    rb = rd_n;
    tx_buf[0] = 8'h83; tx_buf[1] = 8'h00;
    for (int i = 2; i < 6; i++) tx_buf[i] = 8'h00;
    frame(6);
    chk(rd_n - rb == 1, "R9 read trailing no access", rd_n - rb, 1);
    chk(rx_buf[4] == 0 && rx_buf[5] == 0, "R9 miso low after burst", {rx_buf[4], rx_buf[5]}, 0);

    // R10: abort in the middle of the second word
    wb = wr_n;
    tx_buf[0] = 8'h90; tx_buf[1] = 8'h81; tx_buf[2] = 8'h55; tx_buf[3] = 8'h66; tx_buf[4] = 8'h77;
    frame(5);
    chk(wr_n - wb == 1 && wr_data[wb] == 16'h5566, "R10 partial word dropped", wr_n - wb, 1);
    rb = rd_n;
    tx_buf[0] = 8'h91; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    frame(4);
    w = {rx_buf[2], rx_buf[3]};
    chk(rd_n - rb == 1 && w == mdl(1'b0, 8'd0, 7'h11), "R10 parser restarts", w, mdl(1'b0, 8'd0, 7'h11));

    // R11: first byte with bit 7 clear
    wb = wr_n; rb = rd_n;
    tx_buf[0] = 8'h05; tx_buf[1] = 8'h81; tx_buf[2] = 8'h11; tx_buf[3] = 8'h22;
    tx_buf[4] = 8'h33; tx_buf[5] = 8'h44;
    frame(6);
    chk(wr_n == wb && rd_n == rb, "R11 no access", wr_n - wb + rd_n - rb, 0);
    chk(rx_buf[2] == 0 && rx_buf[3] == 0 && rx_buf[5] == 0, "R11 miso low",
        {rx_buf[2], rx_buf[3]}, 0);

    chk(dbl_req == 0, "R12 single-cycle request", dbl_req, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule